// File: doc/BRIEF.md
# Sub-word register access adapter

This block fronts a 128-byte, little-endian host I/O window and serves it from register targets that only accept whole 32-bit words. A host access carries a byte offset and a size of one, two or four bytes. The adapter sorts the offset into one of three regions: a bank of core registers, a bank of DMA registers and a single bus-control word. It then drives a shared word index together with one write strobe or one read strobe for the selected region.

Word writes that are aligned pass straight through. A narrower or misaligned write is widened into one aligned word write. The adapter takes the current value of the addressed word from that region's read-data input, overlays only the host bytes on it and issues the merged word. For a read, the addressed word is shifted down to the requested byte and masked to the access width. The result comes back one cycle after the request. The register side effects themselves live in the targets; this block only decides which word is touched and when.

Top module: `swa_adapter`

## Requirements
- R1: Offsets 0x00 to 0x3F address the core bank (strobe bit 0) at word index offset>>2, for reads and writes of any byte offset.
- R2: Offsets 0x40 to 0x5F address the DMA bank (strobe bit 1) at word index (offset-0x40)>>2.
- R3: A write touching any byte of 0x70 to 0x73 becomes one word write to the bus-control register (strobe bit 2), merged with its current value.
- R4: Writes whose aligned word is 0x60 to 0x6C or 0x74 to 0x7C raise no write strobe, so no target changes.
- R5: A read hits the bus-control register only at offset exactly 0x70. Reads of 0x60 to 0x6F, 0x71 to 0x7F return zero and raise no read strobe.
- R6: host_size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 both mean 4 bytes.
- R7: A 4-byte write at an aligned offset in a decoded region presents the host data unchanged as the word data.
- R8: A narrow or misaligned write puts host byte k into lane (offset mod 4)+k, leaves every other lane at the word's current value, and raises exactly one write strobe.
- R9: Bytes of an access that would pass lane 3 are dropped; the following word is not touched.
- R10: Read data equals the addressed word shifted right by 8 times (offset mod 4), masked to 8 times the access size. It is presented with host_rvalid high for exactly one cycle, in the cycle after the request.
- R11: Each host read of a decoded region raises its read strobe exactly once, whatever the size.
- R12: After reset host_rvalid and host_rdata are zero, and no strobe is raised while host_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Single-cycle access request |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 7 | Byte offset in the window |
| host_size | input | 2 | Access size code (see R6) |
| host_wdata | input | 32 | Write bytes, least significant byte first |
| host_rdata | output | 32 | Aligned, masked read data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| word_idx | output | 4 | Word index within the selected region |
| word_wdata | output | 32 | Full word to be written |
| wr_stb | output | 3 | Write strobe per region: bit 0 core, 1 DMA, 2 bus control |
| rd_stb | output | 3 | Read strobe per region, same order |
| core_rdata | input | 32 | Current value of the core word at word_idx |
| dma_rdata | input | 32 | Current value of the DMA word at word_idx |
| busc_rdata | input | 32 | Current value of the bus-control word |

## Verification
The bench targets the lane arithmetic. It uses byte and halfword writes at every lane offset, accesses that run past lane 3, and the size code that aliases to a word. A design that shifted the wrong way or masked too wide would corrupt neighbouring bytes, or write into the following word. It also probes the asymmetric bus-control decode, where sub-word writes at 0x71 to 0x73 land in the register but reads there return zero. A design that decoded reads like writes would return register contents there. Read strobes are counted per access, so a design that fetched through the strobe path during a merge, or strobed once per byte, would show extra side-effect pulses.

// File: rtl/swa_pkg.sv
package swa_pkg;

    // Window geometry
    localparam int ADDR_W     = 7;
    localparam int BYTES      = 4;
    localparam int DW         = BYTES * 8;
    localparam int CORE_WORDS = 16;
    localparam int DMA_WORDS  = 8;
    localparam int BUSC_OFF   = 'h70;
    localparam int NREG       = 3;

    // Derived
    localparam int IDX_W    = $clog2(CORE_WORDS);
    localparam int LANE_W   = $clog2(BYTES);
    localparam int CORE_END = CORE_WORDS * BYTES;
    localparam int DMA_END  = CORE_END + DMA_WORDS * BYTES;

    typedef enum logic [1:0] {
        RG_CORE = 2'd0,
        RG_DMA  = 2'd1,
        RG_BUSC = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [IDX_W-1:0]   idx;
    } target_t;

    // Number of bytes for a size code; code 3 aliases to a full word.
    function automatic logic [LANE_W:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return (LANE_W+1)'(1);
            2'd1:    return (LANE_W+1)'(2);
            default: return (LANE_W+1)'(BYTES);
        endcase
    endfunction

    // Byte lanes covered by an access, truncated at the word boundary.
    function automatic logic [BYTES-1:0] lane_mask(input logic [1:0] code,
                                                   input logic [LANE_W-1:0] off);
        logic [2*BYTES-1:0] span;
        span = ((2*BYTES)'(1) << size_bytes(code)) - (2*BYTES)'(1);
        span = span << off;
        return span[BYTES-1:0];
    endfunction

endpackage

// File: rtl/swa_decode.sv
module swa_decode
    import swa_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output target_t           wr_tgt,
    output target_t           rd_tgt
);

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] dma_rel;
    target_t           bank_tgt;

    assign waddr   = {addr[ADDR_W-1:LANE_W], LANE_W'(0)};
    assign dma_rel = waddr - ADDR_W'(CORE_END);

    // Banked regions: any byte offset selects the containing word
    always_comb begin
        bank_tgt.region = RG_NONE;
        bank_tgt.idx    = '0;
        if (waddr < ADDR_W'(CORE_END)) begin
            bank_tgt.region = RG_CORE;
            bank_tgt.idx    = IDX_W'(waddr >> LANE_W);
        end else if (waddr < ADDR_W'(DMA_END)) begin
            bank_tgt.region = RG_DMA;
            bank_tgt.idx    = IDX_W'(dma_rel >> LANE_W);
        end
    end

    // Writes are widened to the aligned word first, so every byte of the
    // bus-control word reaches it.
    always_comb begin
        wr_tgt = bank_tgt;
        if (waddr == ADDR_W'(BUSC_OFF)) begin
            wr_tgt.region = RG_BUSC;
            wr_tgt.idx    = '0;
        end
    end

    // Reads of the bus-control word hit only at its exact offset.
    always_comb begin
        rd_tgt = bank_tgt;
        if (addr == ADDR_W'(BUSC_OFF)) begin
            rd_tgt.region = RG_BUSC;
            rd_tgt.idx    = '0;
        end
    end

endmodule

// File: rtl/swa_merge.sv
module swa_merge
    import swa_pkg::*;
(
    input  logic [DW-1:0]     cur,
    input  logic [DW-1:0]     wdata,
    input  logic [LANE_W-1:0] off,
    input  logic [1:0]        size,
    output logic [DW-1:0]     merged
);

    logic [BYTES-1:0] lanes;
    logic [DW-1:0]    placed;

    assign lanes  = lane_mask(size, off);
    assign placed = wdata << {off, 3'b000};

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign merged[g*8 +: 8] = lanes[g] ? placed[g*8 +: 8] : cur[g*8 +: 8];
    end

endmodule

// File: rtl/swa_align.sv
module swa_align
    import swa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [LANE_W-1:0] off,
    input  logic [1:0]        size,
    input  logic [DW-1:0]     word,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);

    logic [DW-1:0] shifted;
    logic [DW-1:0] keep;

    assign shifted = word >> {off, 3'b000};

    always_comb begin
        case (size)
            2'd0:    keep = DW'(8'hFF);
            2'd1:    keep = DW'(16'hFFFF);
            default: keep = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= fire;
            if (fire) rdata <= shifted & keep;
        end
    end

endmodule

// File: rtl/swa_adapter.sv
module swa_adapter
    import swa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_rvalid,
    output logic [IDX_W-1:0]  word_idx,
    output logic [DW-1:0]     word_wdata,
    output logic [NREG-1:0]   wr_stb,
    output logic [NREG-1:0]   rd_stb,
    input  logic [DW-1:0]     core_rdata,
    input  logic [DW-1:0]     dma_rdata,
    input  logic [DW-1:0]     busc_rdata
);

    target_t       wr_tgt, rd_tgt;
    logic [DW-1:0] cur_word;
    logic [DW-1:0] rd_word;
    logic          rd_fire;

    swa_decode u_dec (
        .addr   (host_addr),
        .wr_tgt (wr_tgt),
        .rd_tgt (rd_tgt)
    );

    assign word_idx = host_we ? wr_tgt.idx : rd_tgt.idx;

    function automatic logic [DW-1:0] pick(input region_e r,
                                           input logic [DW-1:0] c,
                                           input logic [DW-1:0] d,
                                           input logic [DW-1:0] b);
        case (r)
            RG_CORE: return c;
            RG_DMA:  return d;
            RG_BUSC: return b;
            default: return '0;
        endcase
    endfunction

    // Current contents for merging are peeked, not strobed
    assign cur_word = pick(wr_tgt.region, core_rdata, dma_rdata, busc_rdata);
    assign rd_word  = pick(rd_tgt.region, core_rdata, dma_rdata, busc_rdata);

    swa_merge u_merge (
        .cur    (cur_word),
        .wdata  (host_wdata),
        .off    (host_addr[LANE_W-1:0]),
        .size   (host_size),
        .merged (word_wdata)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_stb
        assign wr_stb[r] = host_req &  host_we & (wr_tgt.region == region_e'(r));
        assign rd_stb[r] = host_req & ~host_we & (rd_tgt.region == region_e'(r));
    end

    assign rd_fire = host_req & ~host_we;

    swa_align u_align (
        .clk    (clk),
        .rst    (rst),
        .fire   (rd_fire),
        .off    (host_addr[LANE_W-1:0]),
        .size   (host_size),
        .word   (rd_word),
        .rdata  (host_rdata),
        .rvalid (host_rvalid)
    );

    // At most one region strobed per access (R8, R11)
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_stb, rd_stb}));

    // No strobe without a request (R12)
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !host_req |-> (wr_stb == '0 && rd_stb == '0));

    // Read data valid exactly one cycle after a read request (R10)
    a_r10_rvalid_timing: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_req && !host_we));

    a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_we) |=> host_rvalid);

    // Unstrobed read returns zero (R5)
    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rvalid && $past(rd_stb) == '0) |-> host_rdata == '0);

    // Gap and tail writes touch nothing (R4)
    a_r4_gap_write: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_addr >= ADDR_W'(DMA_END) &&
         host_addr[ADDR_W-1:LANE_W] != (ADDR_W-LANE_W)'(BUSC_OFF >> LANE_W))
        |-> wr_stb == '0);

    // Aligned full-word write passes the host word through (R7)
    a_r7_word_passthru: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_size[1] && host_addr[LANE_W-1:0] == '0)
        |-> word_wdata == host_wdata);

    // Byte write at lane 0 keeps the upper lanes of the current word (R8)
    a_r8_keep_upper: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_size == 2'd0 && host_addr[LANE_W-1:0] == '0)
        |-> (word_wdata[DW-1:8] == cur_word[DW-1:8] &&
             word_wdata[7:0] == host_wdata[7:0]));

endmodule

// File: tb/sim_swa_adapter.sv
module sim_swa_adapter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [3:0]  word_idx;
    logic [31:0] word_wdata;
    logic [2:0]  wr_stb, rd_stb;
    logic [31:0] core_rdata, dma_rdata, busc_rdata;

    logic [31:0] core_m [16];
    logic [31:0] dma_m  [8];
    logic [31:0] busc_m;
    int wr_cnt [3];
    int rd_cnt [3];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    swa_adapter u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .word_idx(word_idx), .word_wdata(word_wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb),
        .core_rdata(core_rdata), .dma_rdata(dma_rdata), .busc_rdata(busc_rdata)
    );

    // Downstream register model
    assign core_rdata = core_m[word_idx];
    assign dma_rdata  = dma_m[word_idx[2:0]];
    assign busc_rdata = busc_m;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) core_m[i] <= {8'h11, 8'(i), 8'h5A, 8'hC3};
            for (int i = 0; i < 8; i++)  dma_m[i]  <= {8'h22, 8'(i), 8'hA5, 8'h3C};
            busc_m <= 32'h3300_00F0;
            for (int r = 0; r < 3; r++) begin
                wr_cnt[r] <= 0;
                rd_cnt[r] <= 0;
            end
        end else begin
            if (wr_stb[0]) core_m[word_idx] <= word_wdata;
            if (wr_stb[1]) dma_m[word_idx[2:0]] <= word_wdata;
            if (wr_stb[2]) busc_m <= word_wdata;
            for (int r = 0; r < 3; r++) begin
                if (wr_stb[r]) wr_cnt[r] <= wr_cnt[r] + 1;
                if (rd_stb[r]) rd_cnt[r] <= rd_cnt[r] + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [6:0] a,
                                              input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] r = old;
        int off = int'(a[1:0]);
        for (int b = 0; b < 4; b++)
            if (b >= off && b < off + nbytes(sz)) r[b*8 +: 8] = d[(b-off)*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] w, input logic [6:0] a,
                                             input logic [1:0] sz);
        logic [31:0] r = 0;
        int off = int'(a[1:0]);
        for (int b = 0; b < 4; b++)
            if (b < nbytes(sz) && b + off < 4) r[b*8 +: 8] = w[(b+off)*8 +: 8];
        return r;
    endfunction

    task automatic hw(input logic [6:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = a; host_size = sz; host_wdata = d;
        @(negedge clk);
        host_req = 0; host_we = 0;
    endtask

    task automatic hr(input logic [6:0] a, input logic [1:0] sz,
                      output logic [31:0] d, output logic v);
        @(negedge clk);
        host_req = 1; host_we = 0; host_addr = a; host_size = sz;
        @(negedge clk);
        host_req = 0;
        d = host_rdata;
        v = host_rvalid;
    endtask

    task automatic t_reset;
        chk("R12 rvalid", 32'(host_rvalid), 0);
        chk("R12 rdata", host_rdata, 0);
        repeat (3) @(negedge clk);
        chk("R12 no strobes", 32'(wr_cnt[0] + wr_cnt[1] + wr_cnt[2] + rd_cnt[0] + rd_cnt[1] + rd_cnt[2]), 0);
    endtask

    task automatic t_full_write;
        int c0 = wr_cnt[0];
        hw(7'h14, 2'd2, 32'hA1B2_C3D4);
        chk("R1 R7 core word 5", core_m[5], 32'hA1B2_C3D4);
        chk("R8 single strobe", 32'(wr_cnt[0] - c0), 1);
        hw(7'h48, 2'd2, 32'h0BAD_F00D);
        chk("R2 R7 dma word 2", dma_m[2], 32'h0BAD_F00D);
        hw(7'h04, 2'd3, 32'h1357_9BDF);
        chk("R6 size code 3 full word", core_m[1], 32'h1357_9BDF);
    endtask

    task automatic t_narrow_write;
        logic [31:0] e;
        e = exp_merge(core_m[8], 7'h21, 2'd0, 32'hFFFF_FF55);
        hw(7'h21, 2'd0, 32'hFFFF_FF55);
        chk("R8 byte lane 1", core_m[8], e);
        e = exp_merge(dma_m[7], 7'h5E, 2'd1, 32'hFFFF_9876);
        hw(7'h5E, 2'd1, 32'hFFFF_9876);
        chk("R2 R8 half lane 2", dma_m[7], e);
        e = exp_merge(core_m[3], 7'h0C, 2'd0, 32'h0000_00EE);
        hw(7'h0C, 2'd0, 32'h0000_00EE);
        chk("R6 R8 byte lane 0", core_m[3], e);
    endtask

    task automatic t_cross;
        logic [31:0] e1, n2, e3;
        e1 = exp_merge(core_m[1], 7'h07, 2'd1, 32'h0000_BEEF);
        n2 = core_m[2];
        hw(7'h07, 2'd1, 32'h0000_BEEF);
        chk("R9 half at lane 3", core_m[1], e1);
        chk("R9 next word untouched", core_m[2], n2);
        e3 = exp_merge(dma_m[0], 7'h42, 2'd2, 32'hCAFE_D00D);
        hw(7'h42, 2'd2, 32'hCAFE_D00D);
        chk("R9 word at lane 2", dma_m[0], e3);
    endtask

    task automatic t_gap_write;
        int tot = wr_cnt[0] + wr_cnt[1] + wr_cnt[2];
        logic [31:0] b = busc_m;
        hw(7'h60, 2'd2, 32'hDEAD_BEEF);
        hw(7'h6D, 2'd0, 32'h0000_0077);
        hw(7'h74, 2'd2, 32'h1234_5678);
        hw(7'h7F, 2'd0, 32'h0000_0099);
        chk("R4 no write strobes", 32'(wr_cnt[0] + wr_cnt[1] + wr_cnt[2] - tot), 0);
        chk("R4 bus-control unchanged", busc_m, b);
    endtask

    task automatic t_busc_write;
        logic [31:0] e;
        hw(7'h70, 2'd2, 32'h8000_0001);
        chk("R3 bus-control word", busc_m, 32'h8000_0001);
        e = exp_merge(busc_m, 7'h72, 2'd0, 32'h0000_0042);
        hw(7'h72, 2'd0, 32'h0000_0042);
        chk("R3 bus-control byte lane 2", busc_m, e);
        e = exp_merge(busc_m, 7'h71, 2'd1, 32'h0000_ABCD);
        hw(7'h71, 2'd1, 32'h0000_ABCD);
        chk("R3 bus-control half lane 1", busc_m, e);
    endtask

    task automatic t_reads;
        logic [31:0] d;
        logic v;
        int c0 = rd_cnt[0];
        hr(7'h14, 2'd2, d, v);
        chk("R10 rvalid", 32'(v), 1);
        chk("R1 R10 word read", d, core_m[5]);
        @(negedge clk);
        chk("R10 rvalid one cycle", 32'(host_rvalid), 0);
        hr(7'h15, 2'd0, d, v);
        chk("R10 byte lane 1", d, exp_read(core_m[5], 7'h15, 2'd0));
        hr(7'h16, 2'd1, d, v);
        chk("R10 half lane 2", d, exp_read(core_m[5], 7'h16, 2'd1));
        chk("R11 one strobe per read", 32'(rd_cnt[0] - c0), 3);
        hr(7'h43, 2'd0, d, v);
        chk("R2 R10 dma byte lane 3", d, exp_read(dma_m[0], 7'h43, 2'd0));
        hr(7'h3E, 2'd3, d, v);
        chk("R6 R9 size 3 read at lane 2", d, exp_read(core_m[15], 7'h3E, 2'd3));
        hr(7'h70, 2'd2, d, v);
        chk("R10 bus-control word read", d, busc_m);
        chk("R11 bus-control strobe", 32'(rd_cnt[2]), 1);
    endtask

    task automatic t_unmapped_read;
        logic [31:0] d;
        logic v;
        int tot = rd_cnt[0] + rd_cnt[1] + rd_cnt[2];
        hr(7'h71, 2'd0, d, v);
        chk("R5 read 0x71 zero", d, 0);
        chk("R5 rvalid on unmapped", 32'(v), 1);
        hr(7'h64, 2'd2, d, v);
        chk("R5 read 0x64 zero", d, 0);
        hr(7'h7C, 2'd2, d, v);
        chk("R5 read 0x7C zero", d, 0);
        chk("R5 no read strobes", 32'(rd_cnt[0] + rd_cnt[1] + rd_cnt[2] - tot), 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_full_write;
        t_narrow_write;
        t_cross;
        t_gap_write;
        t_busc_write;
        t_reads;
        t_unmapped_read;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule